// File: doc/BRIEF.md
# Flash Operation Mode Controller

This block is the control front end of an embedded flash array. Software drives it through a 32-bit register port. The mode word holds program, erase and erase-suspend bits and a start bit that applies high voltage. The bus side issues array page reads and interlock writes. An interlock write latches the target page address and the 128-bit data. A later start runs a program or erase for a fixed number of cycles, and the done flag then reports completion.

The array only answers reads when the block is in a read state: either no modify is selected, or an erase is held in suspend. A program touches one page. An erase clears every page of the blocks that are selected and unlocked. Blocks that the address space decodes but that are not fitted behave as locked, and their reads return zeros. An asynchronous reset ends any operation at once and returns every register to its default. The array content is left as it was.

Top module: `flash_mode_ctrl`

## Requirements
- R1: After reset, hv_en_o, busy_o, done_o, conflict_o and arr_rd_ok_o are 0, and the registers at addresses 0, 1 and 2 read 0.
- R2: An array read issued while the mode bits are {prog,erase,susp} = 000, or erase=1 with susp=1 and prog=0, is granted one cycle later. In that cycle arr_rd_ok_o=1 and arr_rdata_o holds the page.
- R3: In every other mode, including after done and until the mode is cleared, an array read gives arr_rd_ok_o=0 and arr_rdata_o=0.
- R4: Address 0 is the mode register: bit0 prog, bit1 erase, bit2 susp, bit3 start on write and high voltage on read, bit4 interlock (read only), bit5 busy (read only), bit6 done (read only). Address 1 holds the per-block lock bits and address 2 the per-block erase selects. Any other address reads 0, and writes to it change nothing.
- R5: A mode write is ignored if it would give any of the following: prog and erase both set; susp set without erase; a prog or erase change while busy; a switch between program and erase while an interlock or done is held. A write with prog=0 and erase=0 is the exception and clears the interlock and done flags.
- R6: A start without a latched interlock does nothing. With an interlock, busy_o is high for exactly OP_CYCLES cycles when no suspend occurs. done_o then sets and the interlock flag clears. hv_en_o is only ever high while busy_o is high.
- R7: A program writes the latched data into the latched page. It does so only if that page's block is fitted and its lock bit is 0. Otherwise the page keeps its content.
- R8: An interlock write to a block that is not fitted still sets the interlock flag. The program that follows changes nothing, and reads of that block return zeros.
- R9: An erase sets every page of each fitted block that is selected and unlocked to all ones. This holds even when the interlock went to a block that is not fitted.
- R10: Setting susp during an erase drops hv_en_o, keeps busy_o high and freezes the remaining cycle count. While suspended, array reads are granted. Clearing susp resumes the erase and completes the remaining cycles.
- R11: A register access in the same cycle as an interlock write is dropped. A write in that cycle has no effect and a read in that cycle returns 0. conflict_o is 1 in the following cycle.
- R12: Reset during a program or erase drops hv_en_o and busy_o at once, clears every register, and leaves the target page unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_en_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Register write when 1, read when 0 |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid in the cycle of the read |
| arr_rd_i | input | 1 | Array page read request |
| arr_wr_i | input | 1 | Array interlock write |
| arr_addr_i | input | PAW | Page address for read or interlock |
| arr_wdata_i | input | 128 | Interlock write data (one page) |
| arr_rdata_o | output | 128 | Page read data, one cycle after the request |
| arr_rd_ok_o | output | 1 | Read granted, aligned with arr_rdata_o |
| hv_en_o | output | 1 | High-voltage enable |
| busy_o | output | 1 | Operation in progress, including suspend |
| done_o | output | 1 | Last operation completed |
| conflict_o | output | 1 | Register access collided with an interlock write |

## Verification
The bench runs a single erase with no interlock and then with one. It programs an unlocked page, a locked page and a page in a block that is not fitted, and it erases two blocks from an interlock in that absent block. These cases separate lock handling and the fitted-block mask from the basic sequencing. An erase is suspended part-way and resumed, and the completion cycle is compared exactly, which shows whether the count really froze. Array reads are issued in every mode, both before and after the mode is cleared, to tell the read-state rule apart from a plain busy gate. The illegal mode writes, the colliding register access and a mid-operation reset each have their register and array state read back afterwards.

// File: rtl/fmc_pkg.sv
package fmc_pkg;

  typedef struct packed {
    logic susp;
    logic erase;
    logic prog;
  } mode_t;

  localparam logic [3:0] ADDR_MODE = 4'd0;
  localparam logic [3:0] ADDR_LOCK = 4'd1;
  localparam logic [3:0] ADDR_ESEL = 4'd2;

  function automatic logic mode_legal(input mode_t cur, input mode_t nxt,
                                      input logic running, input logic held);
    logic ok;
    logic pe_change;
    pe_change = (nxt.prog != cur.prog) || (nxt.erase != cur.erase);
    ok = !(nxt.prog && nxt.erase) && !(nxt.susp && !nxt.erase);
    if (running && pe_change) ok = 1'b0;
    if (!running && held && pe_change && (nxt.prog || nxt.erase)) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic read_state(input mode_t m);
    return (!m.prog && !m.erase) || (m.erase && m.susp && !m.prog);
  endfunction

endpackage

// File: rtl/fmc_regs.sv
module fmc_regs
  import fmc_pkg::*;
#(
  parameter int NUM_BLOCKS = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_en_i,
  input  logic                  reg_we_i,
  input  logic [3:0]            reg_addr_i,
  input  logic [31:0]           reg_wdata_i,
  input  logic                  arr_wr_i,
  input  logic                  running_i,
  input  logic                  ilk_i,
  input  logic                  done_i,
  input  logic                  hv_i,
  output mode_t                 mode_o,
  output logic [NUM_BLOCKS-1:0] lock_o,
  output logic [NUM_BLOCKS-1:0] esel_o,
  output logic                  start_o,
  output logic                  clear_o,
  output logic                  conflict_o,
  output logic [31:0]           reg_rdata_o
);

  mode_t                 mode_q;
  logic [NUM_BLOCKS-1:0] lock_q, esel_q;
  logic                  conflict_q;
  logic                  acc, wr, mode_wr;
  mode_t                 nxt_mode;

  // access is dropped when it collides with an interlock write
  assign acc      = reg_en_i && !arr_wr_i;
  assign wr       = acc && reg_we_i;
  assign nxt_mode = mode_t'(reg_wdata_i[2:0]);
  assign mode_wr  = wr && (reg_addr_i == ADDR_MODE) &&
                    mode_legal(mode_q, nxt_mode, running_i, ilk_i || done_i);
  assign start_o  = mode_wr && reg_wdata_i[3] && ilk_i && !running_i &&
                    (nxt_mode.prog || nxt_mode.erase) && !nxt_mode.susp;
  assign clear_o  = mode_wr && !nxt_mode.prog && !nxt_mode.erase;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= '0;
      lock_q     <= '0;
      esel_q     <= '0;
      conflict_q <= 1'b0;
    end else begin
      conflict_q <= reg_en_i && arr_wr_i;
      if (mode_wr) mode_q <= nxt_mode;
      if (wr && !running_i && reg_addr_i == ADDR_LOCK) lock_q <= reg_wdata_i[NUM_BLOCKS-1:0];
      if (wr && !running_i && reg_addr_i == ADDR_ESEL) esel_q <= reg_wdata_i[NUM_BLOCKS-1:0];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (acc && !reg_we_i) begin
      case (reg_addr_i)
        ADDR_MODE: reg_rdata_o[6:0] = {done_i, running_i, ilk_i, hv_i,
                                       mode_q.susp, mode_q.erase, mode_q.prog};
        ADDR_LOCK: reg_rdata_o[NUM_BLOCKS-1:0] = lock_q;
        ADDR_ESEL: reg_rdata_o[NUM_BLOCKS-1:0] = esel_q;
        default:   reg_rdata_o = '0;
      endcase
    end
  end

  assign mode_o     = mode_q;
  assign lock_o     = lock_q;
  assign esel_o     = esel_q;
  assign conflict_o = conflict_q;

  a_r5_no_prog_and_erase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mode_q.prog && mode_q.erase));
  a_r5_susp_needs_erase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q.susp |-> mode_q.erase);
  a_r11_collision_drops_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_en_i && reg_we_i && arr_wr_i) |=> ($stable(mode_q) && $stable(lock_q) && $stable(esel_q)));

endmodule

// File: rtl/fmc_seq.sv
module fmc_seq #(
  parameter int OP_CYCLES = 8,
  parameter int PAW       = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           susp_i,
  input  logic           pe_i,
  input  logic           start_i,
  input  logic           clear_i,
  input  logic           ilk_wr_i,
  input  logic [PAW-1:0] ilk_addr_i,
  input  logic [127:0]   ilk_data_i,
  output logic           run_o,
  output logic           hv_o,
  output logic           done_o,
  output logic           ilk_o,
  output logic           fire_o,
  output logic [PAW-1:0] tgt_addr_o,
  output logic [127:0]   tgt_data_o
);

  localparam int CW = $clog2(OP_CYCLES + 1);

  logic           run_q, done_q, ilk_q;
  logic [CW-1:0]  cnt_q;
  logic [PAW-1:0] addr_q;
  logic [127:0]   data_q;

  assign fire_o = run_q && !susp_i && (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      ilk_q  <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (start_i) begin
        run_q  <= 1'b1;
        cnt_q  <= CW'(OP_CYCLES);
        done_q <= 1'b0;
      end else if (run_q && !susp_i) begin
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
          ilk_q  <= 1'b0;
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
      end
      if (ilk_wr_i && pe_i && !ilk_q && !run_q) begin
        ilk_q  <= 1'b1;
        addr_q <= ilk_addr_i;
        data_q <= ilk_data_i;
      end
      if (clear_i) begin
        ilk_q  <= 1'b0;
        done_q <= 1'b0;
      end
    end
  end

  assign run_o      = run_q;
  assign hv_o       = run_q && !susp_i;
  assign done_o     = done_q;
  assign ilk_o      = ilk_q;
  assign tgt_addr_o = addr_q;
  assign tgt_data_o = data_q;

  a_r6_hv_within_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hv_o |-> run_q);
  a_r6_start_needs_interlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> $past(ilk_q));
  a_r6_done_on_finish: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_q) |-> done_q);
  a_r10_suspend_freezes_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && susp_i) |=> $stable(cnt_q));

endmodule

// File: rtl/fmc_array.sv
module fmc_array #(
  parameter int                    NUM_BLOCKS      = 4,
  parameter int                    PAGES_PER_BLOCK = 4,
  parameter logic [NUM_BLOCKS-1:0] PRESENT_MASK    = '1,
  localparam int                   PAGES           = NUM_BLOCKS * PAGES_PER_BLOCK,
  localparam int                   PAW             = $clog2(PAGES),
  localparam int                   PGW             = $clog2(PAGES_PER_BLOCK)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rd_i,
  input  logic                  rd_allow_i,
  input  logic [PAW-1:0]        rd_addr_i,
  input  logic                  fire_i,
  input  logic                  prog_i,
  input  logic                  erase_i,
  input  logic [PAW-1:0]        tgt_addr_i,
  input  logic [127:0]          tgt_data_i,
  input  logic [NUM_BLOCKS-1:0] lock_i,
  input  logic [NUM_BLOCKS-1:0] esel_i,
  output logic                  rd_ok_o,
  output logic [127:0]          rd_data_o
);

  logic [127:0]       page_w [PAGES];
  logic [PAW-PGW-1:0] rd_blk;
  logic               rd_ok_q;
  logic [127:0]       rd_data_q;

  for (genvar g = 0; g < PAGES; g++) begin : g_page
    localparam int BLK = g / PAGES_PER_BLOCK;
    logic [127:0] page_q;
    logic         writable, erasable;
    assign writable = PRESENT_MASK[BLK] && !lock_i[BLK];
    assign erasable = writable && esel_i[BLK];
    always_ff @(posedge clk_i) begin
      if (fire_i) begin
        if (erase_i && erasable)
          page_q <= '1;
        else if (prog_i && writable && tgt_addr_i == PAW'(g))
          page_q <= tgt_data_i;
      end
    end
    assign page_w[g] = page_q;
  end

  assign rd_blk = rd_addr_i[PAW-1:PGW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ok_q   <= 1'b0;
      rd_data_q <= '0;
    end else begin
      rd_ok_q   <= rd_i && rd_allow_i;
      rd_data_q <= (rd_i && rd_allow_i && PRESENT_MASK[rd_blk]) ? page_w[rd_addr_i] : '0;
    end
  end

  assign rd_ok_o   = rd_ok_q;
  assign rd_data_o = rd_data_q;

  a_r8_absent_block_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !PRESENT_MASK[rd_blk]) |=> (rd_data_o == '0));

endmodule

// File: rtl/flash_mode_ctrl.sv
module flash_mode_ctrl
  import fmc_pkg::*;
#(
  parameter int                    NUM_BLOCKS      = 4,
  parameter int                    PAGES_PER_BLOCK = 4,
  parameter logic [NUM_BLOCKS-1:0] PRESENT_MASK    = 4'b0111,
  parameter int                    OP_CYCLES       = 8,
  localparam int                   PAW             = $clog2(NUM_BLOCKS * PAGES_PER_BLOCK)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_en_i,
  input  logic           reg_we_i,
  input  logic [3:0]     reg_addr_i,
  input  logic [31:0]    reg_wdata_i,
  output logic [31:0]    reg_rdata_o,
  input  logic           arr_rd_i,
  input  logic           arr_wr_i,
  input  logic [PAW-1:0] arr_addr_i,
  input  logic [127:0]   arr_wdata_i,
  output logic [127:0]   arr_rdata_o,
  output logic           arr_rd_ok_o,
  output logic           hv_en_o,
  output logic           busy_o,
  output logic           done_o,
  output logic           conflict_o
);

  mode_t                 mode;
  logic [NUM_BLOCKS-1:0] lock, esel;
  logic                  start, clear, run, hv, done, ilk, fire;
  logic [PAW-1:0]        tgt_addr;
  logic [127:0]          tgt_data;

  fmc_regs #(.NUM_BLOCKS(NUM_BLOCKS)) u_regs (
    .clk_i, .rst_ni,
    .reg_en_i, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .arr_wr_i,
    .running_i  (run),
    .ilk_i      (ilk),
    .done_i     (done),
    .hv_i       (hv),
    .mode_o     (mode),
    .lock_o     (lock),
    .esel_o     (esel),
    .start_o    (start),
    .clear_o    (clear),
    .conflict_o (conflict_o),
    .reg_rdata_o
  );

  fmc_seq #(.OP_CYCLES(OP_CYCLES), .PAW(PAW)) u_seq (
    .clk_i, .rst_ni,
    .susp_i     (mode.susp),
    .pe_i       (mode.prog || mode.erase),
    .start_i    (start),
    .clear_i    (clear),
    .ilk_wr_i   (arr_wr_i),
    .ilk_addr_i (arr_addr_i),
    .ilk_data_i (arr_wdata_i),
    .run_o      (run),
    .hv_o       (hv),
    .done_o     (done),
    .ilk_o      (ilk),
    .fire_o     (fire),
    .tgt_addr_o (tgt_addr),
    .tgt_data_o (tgt_data)
  );

  fmc_array #(
    .NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK), .PRESENT_MASK(PRESENT_MASK)
  ) u_array (
    .clk_i, .rst_ni,
    .rd_i       (arr_rd_i),
    .rd_allow_i (read_state(mode)),
    .rd_addr_i  (arr_addr_i),
    .fire_i     (fire),
    .prog_i     (mode.prog),
    .erase_i    (mode.erase),
    .tgt_addr_i (tgt_addr),
    .tgt_data_i (tgt_data),
    .lock_i     (lock),
    .esel_i     (esel),
    .rd_ok_o    (arr_rd_ok_o),
    .rd_data_o  (arr_rdata_o)
  );

  assign hv_en_o = hv;
  assign busy_o  = run;
  assign done_o  = done;

  a_r3_no_read_while_modify: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hv_en_o |=> !arr_rd_ok_o);

endmodule

// File: tb/sim_flash_mode_ctrl.sv
`timescale 1ns/1ps
module sim_flash_mode_ctrl;

  localparam int OPC = 8;
  localparam int NPG = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_en = 1'b0, reg_we = 1'b0;
  logic [3:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         arr_rd = 1'b0, arr_wr = 1'b0;
  logic [3:0]   arr_addr = '0;
  logic [127:0] arr_wdata = '0;
  logic [127:0] arr_rdata;
  logic         rd_ok, hv, busy, done, conflict;

  int  n_chk = 0, n_bad = 0;
  bit  live = 1'b0;
  bit  finished = 1'b0;

  flash_mode_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_en_i(reg_en), .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .arr_rd_i(arr_rd), .arr_wr_i(arr_wr), .arr_addr_i(arr_addr), .arr_wdata_i(arr_wdata),
    .arr_rdata_o(arr_rdata), .arr_rd_ok_o(rd_ok),
    .hv_en_o(hv), .busy_o(busy), .done_o(done), .conflict_o(conflict)
  );

  always #5 clk = ~clk;

  // reference model state
  bit           m_p, m_e, m_s, m_run, m_ilk, m_done, m_ok, m_conf, m_rd_known;
  int           m_left;
  bit [3:0]     m_lock, m_sel;
  bit [3:0]     m_ia;
  bit [127:0]   m_id, m_rdata;
  bit [127:0]   m_mem [NPG];
  bit           m_known [NPG];
  bit           o_p, o_e, o_s, o_run, o_ilk, o_done;
  bit [3:0]     o_lock, o_sel;

  function automatic bit fitted(input int page);
    return (page / 4) != 3;
  endfunction

  function automatic bit [31:0] exp_reg(input int a);
    case (a)
      0: return {25'd0, m_done, m_run, m_ilk, m_run && !m_s, m_s, m_e, m_p};
      1: return {28'd0, m_lock};
      2: return {28'd0, m_sel};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_p = 0; m_e = 0; m_s = 0; m_run = 0; m_ilk = 0; m_done = 0;
      m_ok = 0; m_conf = 0; m_rd_known = 1; m_rdata = '0; m_left = 0;
      m_lock = 0; m_sel = 0; m_ia = 0; m_id = '0;
    end else begin
      o_p = m_p; o_e = m_e; o_s = m_s; o_run = m_run; o_ilk = m_ilk; o_done = m_done;
      o_lock = m_lock; o_sel = m_sel;
      m_conf = reg_en && arr_wr;
      if (arr_rd && ((!o_p && !o_e) || (o_e && o_s && !o_p))) begin
        m_ok = 1;
        if (!fitted(int'(arr_addr))) begin m_rdata = '0; m_rd_known = 1; end
        else begin m_rdata = m_mem[arr_addr]; m_rd_known = m_known[arr_addr]; end
      end else begin
        m_ok = 0; m_rdata = '0; m_rd_known = 1;
      end
      if (o_run && !o_s) begin
        m_left--;
        if (m_left == 0) begin
          m_run = 0; m_done = 1; m_ilk = 0;
          if (o_p && fitted(int'(m_ia)) && !o_lock[m_ia/4]) begin
            m_mem[m_ia] = m_id; m_known[m_ia] = 1;
          end
          if (o_e)
            for (int pg = 0; pg < NPG; pg++)
              if (fitted(pg) && o_sel[pg/4] && !o_lock[pg/4]) begin
                m_mem[pg] = '1; m_known[pg] = 1;
              end
        end
      end
      if (arr_wr && (o_p || o_e) && !o_ilk && !o_run) begin
        m_ilk = 1; m_ia = arr_addr; m_id = arr_wdata;
      end
      if (reg_en && reg_we && !arr_wr) begin
        if (reg_addr == 0) begin
          bit np, ne, ns, ok;
          np = reg_wdata[0]; ne = reg_wdata[1]; ns = reg_wdata[2];
          ok = !(np && ne) && !(ns && !ne);
          if (o_run && (np != o_p || ne != o_e)) ok = 0;
          if (!o_run && (o_ilk || o_done) && (np || ne) && (np != o_p || ne != o_e)) ok = 0;
          if (ok) begin
            m_p = np; m_e = ne; m_s = ns;
            if (!np && !ne) begin m_ilk = 0; m_done = 0; end
            if (reg_wdata[3] && o_ilk && !o_run && (np || ne) && !ns) begin
              m_run = 1; m_left = OPC; m_done = 0;
            end
          end
        end else if (reg_addr == 1 && !o_run) m_lock = reg_wdata[3:0];
        else if (reg_addr == 2 && !o_run) m_sel = reg_wdata[3:0];
      end
    end
  end

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (live && rst_n) begin
      chk("R6 busy", 128'(busy), 128'(m_run));
      chk("R6 hv", 128'(hv), 128'(m_run && !m_s));
      chk("R6 done", 128'(done), 128'(m_done));
      chk("R11 conflict", 128'(conflict), 128'(m_conf));
      chk("R2 rd_ok", 128'(rd_ok), 128'(m_ok));
      if (m_rd_known) chk("R3 rdata", arr_rdata, m_rdata);
    end
  end

  task automatic wr_reg(input int a, input logic [31:0] d);
    @(negedge clk); #1;
    reg_en = 1; reg_we = 1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk); #1;
    reg_en = 0; reg_we = 0;
  endtask

  task automatic rd_reg(input int a, input string tag);
    @(negedge clk); #1;
    reg_en = 1; reg_we = 0; reg_addr = 4'(a);
    #2 chk(tag, 128'(reg_rdata), 128'(exp_reg(a)));
    #1 reg_en = 0;
  endtask

  task automatic ilk_wr(input int a, input logic [127:0] d);
    @(negedge clk); #1;
    arr_wr = 1; arr_addr = 4'(a); arr_wdata = d;
    @(negedge clk); #1;
    arr_wr = 0;
  endtask

  task automatic rd_page(input int a, input string tag, input bit exp_ok,
                         input bit chk_data, input logic [127:0] exp_d);
    @(negedge clk); #1;
    arr_rd = 1; arr_addr = 4'(a);
    @(negedge clk); #1;
    arr_rd = 0;
    chk(tag, 128'(rd_ok), 128'(exp_ok));
    if (chk_data) chk(tag, arr_rdata, exp_d);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
    #1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  localparam logic [127:0] D1 = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
  localparam logic [127:0] D2 = 128'h5a5a_0000_ffff_1234_dead_beef_0f0f_a5a5;

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    live = 1;
    // R1 reset state
    #1;
    chk("R1 hv", 128'(hv), 0); chk("R1 busy", 128'(busy), 0);
    chk("R1 done", 128'(done), 0); chk("R1 conflict", 128'(conflict), 0);
    chk("R1 rd_ok", 128'(rd_ok), 0);
    for (int a = 0; a < 3; a++) rd_reg(a, "R1 reg");
    // R4 map and unmapped space
    wr_reg(5, 32'hffff_ffff);
    rd_reg(5, "R4 unmapped");
    chk("R4 unmapped const", 128'(exp_reg(5)), 0);
    rd_reg(0, "R4 mode after unmapped"); rd_reg(1, "R4 lock after unmapped");
    wr_reg(1, 32'h5);
    rd_reg(1, "R4 lock rw");
    chk("R4 lock model", 128'(m_lock), 128'(4'h5));
    wr_reg(1, 32'h0);
    // erase block 0
    wr_reg(2, 32'h1);
    wr_reg(0, 32'h2);
    wr_reg(0, 32'hA);
    chk("R6 no start without interlock", 128'(busy), 0);
    ilk_wr(0, D2);
    rd_reg(0, "R6 interlock flag");
    wr_reg(0, 32'hA);
    chk("R6 busy after start", 128'(busy), 1);
    rd_page(1, "R3 read during erase", 0, 1, '0);
    wait_idle();
    chk("R6 done after erase", 128'(done), 1);
    rd_page(1, "R3 read after done before clear", 0, 1, '0);
    wr_reg(0, 32'h0);
    rd_page(1, "R9 erased page", 1, 1, '1);
    // program page 2
    wr_reg(0, 32'h1);
    ilk_wr(2, D1);
    wr_reg(0, 32'h9);
    wait_idle();
    wr_reg(0, 32'h0);
    rd_page(2, "R7 programmed page", 1, 1, D1);
    // illegal mode writes
    wr_reg(0, 32'h3);
    rd_reg(0, "R5 prog+erase ignored");
    chk("R5 prog+erase model", 128'(exp_reg(0)), 0);
    wr_reg(0, 32'h4);
    rd_reg(0, "R5 susp alone ignored");
    wr_reg(0, 32'h1);
    ilk_wr(3, D2);
    wr_reg(0, 32'h2);
    rd_reg(0, "R5 switch while held");
    chk("R5 held mode", 128'(exp_reg(0)), 128'(32'h11));
    wr_reg(0, 32'h0);
    // locked program
    wr_reg(1, 32'h1);
    wr_reg(0, 32'h1);
    ilk_wr(3, D2);
    wr_reg(0, 32'h9);
    wait_idle();
    wr_reg(0, 32'h0);
    rd_page(3, "R7 locked page unchanged", 1, 1, '1);
    wr_reg(1, 32'h0);
    // absent block
    wr_reg(0, 32'h1);
    ilk_wr(12, D2);
    rd_reg(0, "R8 interlock on absent block");
    chk("R8 interlock model", 128'(exp_reg(0)), 128'(32'h11));
    wr_reg(0, 32'h9);
    wait_idle();
    chk("R8 done", 128'(done), 1);
    wr_reg(0, 32'h0);
    rd_page(12, "R8 absent read zero", 1, 1, '0);
    // erase via absent interlock
    wr_reg(2, 32'h3);
    wr_reg(0, 32'h2);
    ilk_wr(13, D1);
    wr_reg(0, 32'hA);
    wait_idle();
    wr_reg(0, 32'h0);
    rd_page(2, "R9 block0 erased", 1, 1, '1);
    rd_page(5, "R9 block1 erased", 1, 1, '1);
    // suspend and resume
    wr_reg(2, 32'h2);
    wr_reg(0, 32'h2);
    ilk_wr(4, D1);
    wr_reg(0, 32'hA);
    repeat (3) @(negedge clk);
    wr_reg(0, 32'h6);
    chk("R10 hv off in suspend", 128'(hv), 0);
    chk("R10 busy in suspend", 128'(busy), 1);
    rd_page(0, "R10 read in suspend", 1, 1, '1);
    repeat (6) @(negedge clk);
    #1 chk("R10 still busy", 128'(busy), 1);
    wr_reg(0, 32'h2);
    chk("R10 hv back", 128'(hv), 1);
    wait_idle();
    chk("R10 done after resume", 128'(done), 1);
    wr_reg(0, 32'h0);
    // collision
    @(negedge clk); #1;
    reg_en = 1; reg_we = 1; reg_addr = 4'd1; reg_wdata = 32'hf; arr_wr = 1; arr_addr = 0;
    @(negedge clk); #1;
    reg_en = 0; reg_we = 0; arr_wr = 0;
    chk("R11 conflict flagged", 128'(conflict), 1);
    rd_reg(1, "R11 write dropped");
    chk("R11 lock model", 128'(m_lock), 0);
    // reset during program
    wr_reg(0, 32'h1);
    ilk_wr(0, D1);
    wr_reg(0, 32'h9);
    repeat (3) @(negedge clk);
    #1 rst_n = 0;
    #1;
    chk("R12 hv dropped", 128'(hv), 0);
    chk("R12 busy dropped", 128'(busy), 0);
    @(negedge clk); #1 rst_n = 1;
    for (int a = 0; a < 3; a++) rd_reg(a, "R12 registers default");
    chk("R12 mode model", 128'(exp_reg(0)), 0);
    rd_page(0, "R12 page unchanged", 1, 1, '1);
    repeat (2) @(negedge clk);
    summary();
  end

endmodule